// File: doc/BRIEF.md
# Wake-up Edge Event Controller

This block gathers up to sixty-four asynchronous wake-up sources and turns selected signal transitions on them into one combined wake request. Each source is synchronised and then watched for either a rising or a falling transition, chosen per source. A detected transition sets a sticky status bit. Software enables sources individually, and it acknowledges events by writing ones to the status register.

The sources are grouped into banks of thirty-two. Source number n belongs to bank n[5] and uses bit n[4:0] of that bank's registers. Each bank has four word registers on a small synchronous bus: enable, raw status, masked status and edge polarity. Some source positions are not implemented. They never record an event, and every register bit that belongs to them reads as zero.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, raw status and polarity registers of every bank are zero, `wake_req` is low and `bus_rdata` is zero.
- R2: Bank b has its registers at byte address 0x20 + 0x10*b: enable at +0x0, raw status at +0x4, masked status at +0x8 and polarity at +0xC. Source n maps to bank n[5], bit n[4:0]. `bus_rdata` shows the register addressed in the previous cycle. An address that selects no register reads as zero.
- R3: A polarity bit of 1 selects rising-edge detection for its source, and 0 selects falling-edge detection. A transition on `src_in` that is set up before clock edge k sets the raw status bit at edge k+2. The transition passes through two synchroniser flops and then the latch.
- R4: A raw status bit is set by its selected edge whatever its enable bit holds.
- R5: Writing the raw status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A raw bit is never cleared in any other way.
- R6: If a selected edge and a clearing write reach the same raw bit in the same cycle, the bit stays set.
- R7: Masked status reads as raw status AND enable. A write to the masked status address changes no register.
- R8: `wake_req` is a registered OR of all masked status bits of all banks. It rises one cycle after the first masked bit is set, so it rises at edge k+3 for a transition set up before edge k. It stays low while no source is enabled.
- R9: The unimplemented sources are 6 to 11, 18, 27, 28, 32 to 34, 51 and 59. For these sources the enable, polarity and raw status bits always read as zero, whatever is written to them and whatever the inputs do.
- R10: A source that holds a steady level sets nothing more once its edge has been recorded. After that event is cleared, the raw bit stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | BANK_W (32) | Write data |
| bus_rdata | output | BANK_W (32) | Registered read data for the previous address |
| src_in | input | NUM_BANKS*BANK_W (64) | Asynchronous wake-up source levels |
| wake_req | output | 1 | Registered combined wake request |

## Verification
The bench builds the block with its default parameters: two banks of thirty-two bits, a two-stage synchroniser and the default implemented-source mask. With these values both banks can be reached, including the bank-select boundary at source 32 and the top source 63. The bench checks the exact three-cycle request latency against the synchroniser depth. It also checks the unimplemented-source mask at its real positions and times a clearing write to land in the same cycle as a new edge.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    WK_ENABLE   = 2'd0,
    WK_RAW      = 2'd1,
    WK_MASKED   = 2'd2,
    WK_POLARITY = 2'd3
  } wake_reg_e;

  localparam int unsigned WK_BASE   = 32'h20;
  localparam int unsigned WK_STRIDE = 32'h10;
  localparam int unsigned WK_WORD   = 32'h4;

  // byte address of one register of one bank
  function automatic int unsigned wk_addr(input int unsigned bank, input wake_reg_e kind);
    return WK_BASE + bank * WK_STRIDE + WK_WORD * 32'(kind);
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wake_bank.sv
module wake_bank #(
  parameter int unsigned           BANK_W = 32,
  parameter logic [BANK_W-1:0]     VALID  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lvl_i,
  input  logic              wr_en_i,
  input  logic              wr_clr_i,
  input  logic              wr_pol_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] pol_o,
  output logic [BANK_W-1:0] msk_o
);

  logic [BANK_W-1:0] en_q, pol_q, raw_q, prev_q;
  logic [BANK_W-1:0] hit;
  logic [BANK_W-1:0] clr_bits;

  // per-bit edge select; unimplemented positions are tied off
  for (genvar i = 0; i < int'(BANK_W); i++) begin : g_bit
    if (VALID[i]) begin : g_live
      assign hit[i] = pol_q[i] ? (lvl_i[i] & ~prev_q[i])
                               : (~lvl_i[i] & prev_q[i]);
    end else begin : g_dead
      assign hit[i] = 1'b0;
    end
  end

  assign clr_bits = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      raw_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (wr_en_i)  en_q  <= wdata_i & VALID;
      if (wr_pol_i) pol_q <= wdata_i & VALID;
      // a fresh edge overrides a simultaneous clear
      raw_q <= ((raw_q & ~clr_bits) | hit) & VALID;
    end
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign raw_o = raw_q;
  assign msk_o = raw_q & en_q;

endmodule

// File: rtl/wake_regif.sv
module wake_regif
  import wake_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_we,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]   en_b,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]   raw_b,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]   msk_b,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]   pol_b,
  output logic [NUM_BANKS-1:0]               wr_en_sel,
  output logic [NUM_BANKS-1:0]               wr_clr_sel,
  output logic [NUM_BANKS-1:0]               wr_pol_sel,
  output logic [BANK_W-1:0]                  rdata_q
);

  logic [NUM_BANKS-1:0] hit_en, hit_raw, hit_msk, hit_pol;
  logic [BANK_W-1:0]    rd_nxt;

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(wk_addr(b, WK_ENABLE));
    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(wk_addr(b, WK_RAW));
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(wk_addr(b, WK_MASKED));
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(wk_addr(b, WK_POLARITY));
    assign hit_en[b]     = (bus_addr == A_EN);
    assign hit_raw[b]    = (bus_addr == A_RAW);
    assign hit_msk[b]    = (bus_addr == A_MSK);
    assign hit_pol[b]    = (bus_addr == A_POL);
    assign wr_en_sel[b]  = bus_we & hit_en[b];
    assign wr_clr_sel[b] = bus_we & hit_raw[b];
    assign wr_pol_sel[b] = bus_we & hit_pol[b];
  end

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (hit_en[b])  rd_nxt = en_b[b];
      if (hit_raw[b]) rd_nxt = raw_b[b];
      if (hit_msk[b]) rd_nxt = msk_b[b];
      if (hit_pol[b]) rd_nxt = pol_b[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BANK_W      = 32,
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] SRC_VALID = 64'hF7F7_FFF8_E7FB_F03F
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] src_in,
  output logic                        wake_req
);

  localparam int unsigned NUM_SRC = NUM_BANKS * BANK_W;

  logic [NUM_SRC-1:0]                lvl_all;
  logic [NUM_SRC-1:0]                raw_all, en_all, msk_all;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  en_b, raw_b, msk_b, pol_b;
  logic [NUM_BANKS-1:0]              wr_en_sel, wr_clr_sel, wr_pol_sel;
  logic                              req_q;

  wake_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_in),
    .q_o (lvl_all)
  );

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    wake_bank #(
      .BANK_W (BANK_W),
      .VALID  (SRC_VALID[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .lvl_i    (lvl_all[b*BANK_W +: BANK_W]),
      .wr_en_i  (wr_en_sel[b]),
      .wr_clr_i (wr_clr_sel[b]),
      .wr_pol_i (wr_pol_sel[b]),
      .wdata_i  (bus_wdata),
      .en_o     (en_b[b]),
      .raw_o    (raw_b[b]),
      .pol_o    (pol_b[b]),
      .msk_o    (msk_b[b])
    );
    assign raw_all[b*BANK_W +: BANK_W] = raw_b[b];
    assign en_all[b*BANK_W +: BANK_W]  = en_b[b];
    assign msk_all[b*BANK_W +: BANK_W] = msk_b[b];
  end

  wake_regif #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .en_b       (en_b),
    .raw_b      (raw_b),
    .msk_b      (msk_b),
    .pol_b      (pol_b),
    .wr_en_sel  (wr_en_sel),
    .wr_clr_sel (wr_clr_sel),
    .wr_pol_sel (wr_pol_sel),
    .rdata_q    (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= |msk_all;
  end

  assign wake_req = req_q;

endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk
  import wake_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] SRC_VALID = '1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [BANK_W-1:0]           bus_rdata,
  input logic                        wake_req,
  input logic [NUM_BANKS*BANK_W-1:0] raw_all,
  input logic [NUM_BANKS*BANK_W-1:0] en_all
);

  localparam logic [ADDR_W-1:0] A_MSK0 = ADDR_W'(wk_addr(0, WK_MASKED));

  logic any_raw_wr;
  always_comb begin
    any_raw_wr = 1'b0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (bus_we && bus_addr == ADDR_W'(wk_addr(b, WK_RAW))) any_raw_wr = 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (raw_all == '0 && en_all == '0 && !wake_req)); // R1

  AST_RESERVED_RAW: assert property (@(posedge clk) disable iff (rst)
    (raw_all & ~SRC_VALID) == '0); // R9

  AST_RESERVED_EN: assert property (@(posedge clk) disable iff (rst)
    (en_all & ~SRC_VALID) == '0); // R9

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    !any_raw_wr |=> (($past(raw_all) & ~raw_all) == '0)); // R5

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (en_all == '0) |=> !wake_req); // R8

  AST_REQ_FROM_MASK: assert property (@(posedge clk) disable iff (rst)
    ((raw_all & en_all) != '0) |=> wake_req); // R8

  AST_MSK_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_MSK0) |=>
      (bus_rdata == ($past(raw_all[BANK_W-1:0]) & $past(en_all[BANK_W-1:0])))); // R7

endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W),
  .NUM_BANKS (NUM_BANKS),
  .SRC_VALID (SRC_VALID)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .wake_req  (wake_req),
  .raw_all   (raw_all),
  .en_all    (en_all)
);

// File: tb/wake_evt_ctrl_tb_top.sv
module wake_evt_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_EN0  = 8'h20, A_RAW0 = 8'h24, A_MSK0 = 8'h28, A_POL0 = 8'h2C;
  localparam logic [7:0] A_EN1  = 8'h30, A_RAW1 = 8'h34, A_MSK1 = 8'h38, A_POL1 = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        wake_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_evt_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .wake_req  (wake_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic clear_all();
    cyc(5);
    bus_write(A_RAW0, 32'hFFFF_FFFF);
    bus_write(A_RAW1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 wake_req after reset", {31'b0, wake_req}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(A_EN0, d);  check("R1 enable0", d, 32'h0);
    bus_read(A_RAW1, d); check("R1 raw1", d, 32'h0);
    bus_read(A_POL1, d); check("R1 polarity1", d, 32'h0);
    bus_read(8'h00, d);  check("R2 unmapped 0x00", d, 32'h0);
    bus_read(8'h40, d);  check("R2 unmapped 0x40", d, 32'h0);
  endtask

  task automatic t_reserved_masks();
    logic [31:0] d;
    bus_write(A_EN0, 32'hFFFF_FFFF);
    bus_read(A_EN0, d);  check("R9 enable0 reserved", d, 32'hE7FB_F03F);
    bus_write(A_POL1, 32'hFFFF_FFFF);
    bus_read(A_POL1, d); check("R9 polarity1 reserved", d, 32'hF7F7_FFF8);
    bus_write(A_EN0, 32'h0);
    bus_write(A_POL1, 32'h0);
  endtask

  task automatic t_falling_w1c();
    logic [31:0] d;
    src_in[5] = 1'b1; src_in[0] = 1'b1;
    cyc(5);
    bus_read(A_RAW0, d); check("R3 rise ignored with polarity 0", d, 32'h0);
    src_in[5] = 1'b0; src_in[0] = 1'b0;
    cyc(5);
    bus_read(A_RAW0, d); check("R4 falling edges latch while disabled", d, 32'h21);
    check("R8 no request while disabled", {31'b0, wake_req}, 32'h0);
    bus_write(A_RAW0, 32'h20);
    bus_read(A_RAW0, d); check("R5 W1C clears only ones", d, 32'h01);
    bus_write(A_RAW0, 32'h0);
    bus_read(A_RAW0, d); check("R5 zero write leaves bits", d, 32'h01);
    bus_write(A_RAW0, 32'h01);
    bus_read(A_RAW0, d); check("R5 W1C clears remaining", d, 32'h0);
  endtask

  task automatic t_rising_latency();
    logic [31:0] d;
    bus_write(A_POL1, 32'h8000_0100);
    bus_write(A_EN1, 32'h0000_0100);
    src_in[40] = 1'b1;
    cyc(3);
    check("R8 request low before edge k+3", {31'b0, wake_req}, 32'h0);
    cyc(1);
    check("R3 R8 request high at edge k+3", {31'b0, wake_req}, 32'h1);
    bus_read(A_RAW1, d); check("R2 source 40 maps to bank1 bit8", d, 32'h100);
    bus_read(A_MSK1, d); check("R7 masked status bank1", d, 32'h100);
    bus_write(A_RAW1, 32'h100);
    cyc(6);
    bus_read(A_RAW1, d); check("R10 held level does not re-latch", d, 32'h0);
    check("R8 request drops after clear", {31'b0, wake_req}, 32'h0);
    src_in[63] = 1'b1;
    cyc(5);
    bus_read(A_RAW1, d); check("R2 source 63 maps to bank1 bit31", d, 32'h8000_0000);
  endtask

  task automatic t_mask_write();
    logic [31:0] d;
    bus_read(A_MSK1, d); check("R7 masked hides disabled source", d, 32'h0);
    bus_write(A_MSK1, 32'hFFFF_FFFF);
    bus_read(A_EN1, d);  check("R7 masked write leaves enable", d, 32'h100);
    bus_read(A_RAW1, d); check("R7 masked write leaves raw", d, 32'h8000_0000);
    bus_read(A_MSK1, d); check("R7 masked write ignored", d, 32'h0);
    check("R8 request low with no masked bit", {31'b0, wake_req}, 32'h0);
    bus_write(A_EN1, 32'h8000_0100);
    bus_read(A_MSK1, d); check("R7 masked follows enable", d, 32'h8000_0000);
    check("R8 request from bank1 bit31", {31'b0, wake_req}, 32'h1);
    bus_write(A_EN1, 32'h0);
    bus_write(A_RAW1, 32'hFFFF_FFFF);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    src_in[40] = 1'b0;
    cyc(5);
    src_in[40] = 1'b1;
    cyc(5);
    src_in[40] = 1'b0;
    cyc(5);
    bus_read(A_RAW1, d); check("R6 setup bit8 latched", d, 32'h100);
    src_in[40] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_RAW1; bus_wdata = 32'h100; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    bus_read(A_RAW1, d); check("R6 edge wins over clear", d, 32'h100);
    bus_write(A_RAW1, 32'h100);
    bus_read(A_RAW1, d); check("R5 clear without edge", d, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    bus_write(A_POL1, 32'hFFFF_FFFF);
    bus_write(A_EN0, 32'hFFFF_FFFF);
    bus_write(A_EN1, 32'hFFFF_FFFF);
    clear_all();
    src_in[59] = 1'b1; src_in[33] = 1'b1; src_in[7] = 1'b1;
    cyc(5);
    src_in[7] = 1'b0;
    cyc(5);
    bus_read(A_RAW1, d); check("R9 sources 59 and 33 never latch", d, 32'h0);
    bus_read(A_RAW0, d); check("R9 source 7 never latches", d, 32'h0);
    check("R9 no request from unused sources", {31'b0, wake_req}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_reserved_masks();
    t_falling_w1c();
    t_rising_latency();
    t_mask_write();
    t_collision();
    t_unused();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule